// File: doc/BRIEF.md
# Conversion Result Readout Registers

This block sits between an analog-to-digital conversion engine and a byte-wide processor bus. It keeps the most recent finished conversion code and shows it at two read-only byte addresses, a low address and a high address. What the low address returns depends on two things. The first is the resolution tag that came with the stored code. The second is whether the high address has been read since the last conversion start or the last low-address read. Software that only needs the upper eight bits of a full-width code reads the low address once. Software that wants the whole code reads the high address first and then the low address.

The high address also holds a resolution-select bit in its top position. Software writes this bit, and the block drives it to the conversion engine. Every other written bit is dropped. Each finished conversion arrives with its own resolution tag. The stored code keeps that tag until the next finished conversion replaces it.

Reads come in as single-cycle requests. The block takes one request every cycle, so there is no back-pressure. Each request is answered by a response strobe and data byte exactly one cycle later. Responses come out in request order, and the receiver cannot stall them.

Top module: `adc_readout_regs`

## Requirements
- R1: After reset, `rsp_valid` is 0, `mode_narrow` is 0, the stored code is 0 with a full-width tag, and the order flag is clear, so both addresses read 0x00.
- R2: A read request (`rd_en`=1) yields `rsp_valid`=1 with its data on the following cycle only. A cycle without a request yields `rsp_valid`=0 on the next cycle.
- R3: The stored code and its tag change only in a cycle with `conv_done`=1. Reads between a `start` and the next `conv_done`, including a read in the same cycle as `conv_done`, return the previously stored code.
- R4: When the stored tag is narrow (tag=1), a read of the low address (`rd_sel`=0) returns code bits 7..0, whatever the order flag holds.
- R5: When the stored tag is full width (tag=0) and the order flag is clear, a low-address read returns code bits 9..2.
- R6: When the stored tag is full width and the order flag is set, a low-address read returns code bits 7..0. Every low-address read clears the flag, so the next low-address read returns bits 9..2 again.
- R7: A high-address read (`rd_sel`=1) returns bit 7 = the resolution-select bit, bits 6..2 = 0, and bits 1..0 = code bits 9..8 (0 when the tag is narrow).
- R8: A high-address read with no `start` in the same cycle sets the order flag. A `start` clears the flag and wins over a high-address read in the same cycle.
- R9: A write to the high address (`wr_en`=1, `wr_sel`=1) loads `wr_data` bit 7 into the resolution-select bit. Its other bits, and every write to the low address, change nothing that can be read.
- R10: `mode_narrow` always equals the resolution-select bit. 1 selects 8-bit conversions and 0 selects 10-bit conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion start event, one cycle |
| conv_done | input | 1 | Conversion finished strobe, one cycle |
| conv_code | input | 10 | Finished code; a narrow code sits in bits 7..0 |
| conv_narrow | input | 1 | Tag of the finished code: 1 narrow, 0 full width |
| rd_en | input | 1 | Read request, always accepted |
| rd_sel | input | 1 | Read address: 0 low, 1 high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write address: 0 low, 1 high |
| wr_data | input | 8 | Write data byte |
| rsp_valid | output | 1 | Read response strobe, one cycle after the request |
| rsp_data | output | 8 | Read response byte |
| mode_narrow | output | 1 | Resolution select driven to the conversion engine |

## Verification
The bench builds the block with its default widths: a 10-bit code and an 8-bit bus. At these widths every one of the 1024 codes can be swept under both tags. Each code is read back in the high-first, low-first and repeated-low orders, and the expected bytes come from shifting and masking the swept value. Targeted sequences then cover reads inside the start-to-done window, a read in the same cycle as `conv_done`, a start and a high-address read in the same cycle, and dropped writes.

// File: rtl/adc_readout_pkg.sv
package adc_readout_pkg;

  typedef enum logic {
    ADDR_LO = 1'b0,
    ADDR_HI = 1'b1
  } addr_sel_e;

  typedef struct packed {
    logic lo_rd;
    logic hi_rd;
  } rd_event_t;

endpackage

// File: rtl/adc_code_store.sv
module adc_code_store #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  input  logic              conv_narrow,
  output logic [CODE_W-1:0] code_q,
  output logic              narrow_q
);

  // Only a finished conversion replaces the held code and its tag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      narrow_q <= 1'b0;
    end else if (conv_done) begin
      code_q   <= conv_code;
      narrow_q <= conv_narrow;
    end
  end

endmodule

// File: rtl/adc_order_tracker.sv
module adc_order_tracker
  import adc_readout_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  rd_event_t ev,
  output logic      hi_first_q
);

  // Priority: start clears, then a low read clears, then a high read sets.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_first_q <= 1'b0;
    end else if (start || ev.lo_rd) begin
      hi_first_q <= 1'b0;
    end else if (ev.hi_rd) begin
      hi_first_q <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_read_format.sv
module adc_read_format #(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic              hi_first,
  input  logic              mode_bit,
  input  logic [CODE_W-1:0] code,
  input  logic              narrow,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data
);

  localparam int HI_W  = CODE_W - BYTE_W;
  localparam int PAD_W = BYTE_W - 1 - HI_W;

  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] hi_byte;
  logic [BYTE_W-1:0] sel_byte;
  logic [HI_W-1:0]   top_bits;

  // Low address: MSB-aligned for a full-width code unless high was read first.
  always_comb begin
    if (narrow || hi_first) begin
      lo_byte = code[BYTE_W-1:0];
    end else begin
      lo_byte = code[CODE_W-1 -: BYTE_W];
    end
  end

  assign top_bits = narrow ? '0 : code[CODE_W-1:BYTE_W];

  generate
    if (PAD_W > 0) begin : g_pad
      assign hi_byte = {mode_bit, {PAD_W{1'b0}}, top_bits};
    end else begin : g_nopad
      assign hi_byte = {mode_bit, top_bits};
    end
  endgenerate

  assign sel_byte = rd_sel ? hi_byte : lo_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) begin
        rsp_data <= sel_byte;
      end
    end
  end

endmodule

// File: rtl/adc_readout_regs.sv
module adc_readout_regs
  import adc_readout_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  input  logic              conv_narrow,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              mode_narrow
);

  localparam int MODE_POS = BYTE_W - 1;

  logic [CODE_W-1:0] code_q;
  logic              narrow_q;
  logic              hi_first_q;
  logic              mode_q;
  rd_event_t         ev;
  logic              unused_wr_bits;

  assign ev.lo_rd = rd_en && (addr_sel_e'(rd_sel) == ADDR_LO);
  assign ev.hi_rd = rd_en && (addr_sel_e'(rd_sel) == ADDR_HI);

  // Only the resolution-select bit of the high address is writable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (wr_en && (addr_sel_e'(wr_sel) == ADDR_HI)) begin
      mode_q <= wr_data[MODE_POS];
    end
  end

  assign unused_wr_bits = ^wr_data[MODE_POS-1:0];
  assign mode_narrow    = mode_q;

  adc_code_store #(.CODE_W(CODE_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_done   (conv_done),
    .conv_code   (conv_code),
    .conv_narrow (conv_narrow),
    .code_q      (code_q),
    .narrow_q    (narrow_q)
  );

  adc_order_tracker u_order (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ev         (ev),
    .hi_first_q (hi_first_q)
  );

  adc_read_format #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_fmt (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .hi_first  (hi_first_q),
    .mode_bit  (mode_q),
    .code      (code_q),
    .narrow    (narrow_q),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/adc_readout_chk.sv
module adc_readout_chk #(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              conv_done,
  input logic              rd_en,
  input logic              rd_sel,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [BYTE_W-1:0] wr_data,
  input logic              rsp_valid,
  input logic [BYTE_W-1:0] rsp_data,
  input logic              mode_narrow,
  input logic [CODE_W-1:0] code_q,
  input logic              hi_first_q
);

  localparam int HI_W = CODE_W - BYTE_W;

  a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);

  a_r3_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(code_q));

  a_r7_hi_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel) |=> (rsp_data[BYTE_W-2:HI_W] == '0));

  a_r7_hi_mode_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && !wr_en) |=> (rsp_data[BYTE_W-1] == mode_narrow));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !hi_first_q);

  a_r8_hi_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && !start) |=> hi_first_q);

  a_r6_lo_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel) |=> !hi_first_q);

  a_r9_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (mode_narrow == $past(wr_data[BYTE_W-1])));

  a_r9_lo_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable(mode_narrow));

endmodule

bind adc_readout_regs adc_readout_chk #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .conv_done   (conv_done),
  .rd_en       (rd_en),
  .rd_sel      (rd_sel),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .mode_narrow (mode_narrow),
  .code_q      (code_q),
  .hi_first_q  (hi_first_q)
);

// File: tb/sim_adc_readout_regs.sv
module sim_adc_readout_regs;

  localparam int CODE_W = 10;
  localparam int BYTE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              conv_done = 1'b0;
  logic [CODE_W-1:0] conv_code = '0;
  logic              conv_narrow = 1'b0;
  logic              rd_en = 1'b0;
  logic              rd_sel = 1'b0;
  logic              wr_en = 1'b0;
  logic              wr_sel = 1'b0;
  logic [BYTE_W-1:0] wr_data = '0;
  logic              rsp_valid;
  logic [BYTE_W-1:0] rsp_data;
  logic              mode_narrow;

  int checks = 0;
  int failures = 0;
  logic done_flag = 1'b0;

  always #2.5 clk = ~clk;

  adc_readout_regs #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .conv_done(conv_done),
    .conv_code(conv_code), .conv_narrow(conv_narrow), .rd_en(rd_en),
    .rd_sel(rd_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mode_narrow(mode_narrow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    start = 0; conv_done = 0; rd_en = 0; wr_en = 0;
  endtask

  task automatic finish_conv(input logic [CODE_W-1:0] v, input logic nar);
    @(negedge clk);
    conv_done = 1; conv_code = v; conv_narrow = nar;
    idle();
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1;
    idle();
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    wr_en = 1; wr_sel = 1; wr_data = {m, 7'h55};
    idle();
  endtask

  // Issue a read, then sample the response one cycle later.
  task automatic rd(input logic sel, input int exp, input string req);
    @(negedge clk);
    rd_en = 1; rd_sel = sel;
    @(negedge clk);
    rd_en = 0;
    check({req, " rsp_valid"}, int'(rsp_valid), 1);
    check(req, int'(rsp_data), exp);
  endtask

  function automatic int hi_exp(input int v, input logic nar, input logic m);
    return (int'(m) << 7) | (nar ? 0 : (v >> 8));
  endfunction

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 mode_narrow", int'(mode_narrow), 0);
    rst_n = 1;
    rd(1'b0, 0, "R1 lo after reset");
    rd(1'b1, 0, "R1 hi after reset");
    @(negedge clk);
    check("R2 no request", int'(rsp_valid), 0);

    // Full-width sweep, all codes, mode bit toggled on odd codes.
    for (int v = 0; v < 1024; v++) begin
      logic m;
      m = v[0];
      set_mode(m);
      check("R10 mode_narrow", int'(mode_narrow), int'(m));
      do_start();
      finish_conv(CODE_W'(v), 1'b0);
      rd(1'b0, (v >> 2) & 8'hff, "R5 lo msb-aligned");
      rd(1'b1, hi_exp(v, 1'b0, m), "R7 hi byte");
      rd(1'b0, v & 8'hff, "R6 lo after hi");
      rd(1'b0, (v >> 2) & 8'hff, "R6 lo again");
    end

    // Narrow-tag sweep.
    set_mode(1'b1);
    for (int v = 0; v < 256; v++) begin
      do_start();
      finish_conv(CODE_W'(v), 1'b1);
      rd(1'b0, v, "R4 lo narrow");
      rd(1'b1, hi_exp(v, 1'b1, 1'b1), "R7 hi narrow");
      rd(1'b0, v, "R4 lo narrow after hi");
    end

    // R3: reads during a conversion return the previous code.
    set_mode(1'b0);
    do_start();
    finish_conv(10'h2c7, 1'b0);
    do_start();
    rd(1'b0, 8'hb1, "R3 read during conversion");
    @(negedge clk);
    rd_en = 1; rd_sel = 0; conv_done = 1; conv_code = 10'h0f3; conv_narrow = 0;
    @(negedge clk);
    rd_en = 0; conv_done = 0;
    check("R3 read with done", int'(rsp_data), 8'hb1);
    rd(1'b0, 8'h3c, "R3 new code after done");

    // R8: start and high read in the same cycle; start wins.
    @(negedge clk);
    rd_en = 1; rd_sel = 1; start = 1;
    @(negedge clk);
    rd_en = 0; start = 0;
    check("R8 hi with start", int'(rsp_data), 8'h00);
    rd(1'b0, 8'h3c, "R8 lo after start+hi");
    rd(1'b1, 8'h00, "R8 hi read");
    do_start();
    rd(1'b0, 8'h3c, "R8 start clears flag");

    // R9: writes to low address and extra bits are dropped.
    set_mode(1'b1);
    @(negedge clk);
    wr_en = 1; wr_sel = 0; wr_data = 8'h00;
    idle();
    check("R9 lo write ignored mode", int'(mode_narrow), 1);
    rd(1'b0, 8'h3c, "R9 lo write ignored data");
    @(negedge clk);
    wr_en = 1; wr_sel = 1; wr_data = 8'h7f;
    idle();
    check("R9 hi write bit7", int'(mode_narrow), 0);
    rd(1'b1, 8'h00, "R9 hi readback");

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule